// File: doc/BRIEF.md
# Fixed Interrupt Acceptance and Dispatch

This block keeps the per-processor bookkeeping for 256 interrupt vectors. It screens each incoming message. A message addressed elsewhere is dropped. A message of a non-fixed delivery type is passed straight to the core on a bypass output. A fixed message is latched into a pending-request vector, and its trigger mode is recorded alongside it.

When the core raises its ready signal, the highest pending vector is moved from the pending set to the in-service set and presented to the core. This happens only if that vector's priority class beats the current processor priority, which is derived from the task-priority setting and the highest vector already in service. An end-of-interrupt write retires the highest in-service vector. If that vector arrived level-triggered, the block announces it on a separate pulse output so that the source can be re-sampled.

Top module: `fixint_ctrl`

## Requirements
- R1: A message with `msg_valid` high and `msg_dest_hit` low changes no state: no bypass pulse, no error pulse, and no later dispatch results from it.
- R2: A matching message whose `msg_kind` is not 0 (0 means fixed) is not recorded as pending. On the next cycle `bypass_valid` is high for one cycle, with `bypass_vector` and `bypass_kind` equal to the message's vector and kind.
- R3: A matching fixed message with a legal vector sets the pending bit for that vector. Among pending vectors, the numerically highest is dispatched first.
- R4: When a vector is accepted as pending, its trigger bit is set if `msg_level` is 1 and cleared if it is 0. A later acceptance of the same vector overwrites the bit.
- R5: A dispatch happens only on a cycle with `core_ready` high, and only if the highest pending vector's class (bits [7:4]) is strictly greater than the processor class. One cycle later `disp_valid` pulses for one cycle with `disp_vector`. At most one vector is dispatched per ready cycle.
- R6: `proc_class` equals the larger of the task-priority class (bits [7:4] of the last `tpr_data` written) and the class of the highest in-service vector, or 0 when nothing is in service.
- R7: `eoi_wr` clears the highest in-service vector. If that vector's trigger bit is set, `eoi_level_valid` pulses one cycle later with `eoi_level_vector`. With nothing in service, `eoi_wr` has no effect.
- R8: A matching fixed message with a vector from 0 to 15 is dropped and raises `illegal_err` for exactly one cycle, one cycle later.
- R9: Reset clears the pending, in-service and trigger vectors, the task priority, and all output pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Incoming message present this cycle |
| msg_vector | input | 8 | Vector of the message |
| msg_kind | input | 3 | Delivery type, 0 = fixed, any other value = bypass type |
| msg_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| msg_dest_hit | input | 1 | Message is addressed to this controller |
| core_ready | input | 1 | Core can take the next vector |
| eoi_wr | input | 1 | End-of-interrupt write |
| tpr_wr | input | 1 | Task-priority write strobe |
| tpr_data | input | 8 | Task-priority value |
| disp_valid | output | 1 | One-cycle dispatch pulse |
| disp_vector | output | 8 | Dispatched vector |
| bypass_valid | output | 1 | One-cycle bypass pulse |
| bypass_kind | output | 3 | Kind of the bypassed message |
| bypass_vector | output | 8 | Vector of the bypassed message |
| eoi_level_valid | output | 1 | One-cycle pulse for a retired level-triggered vector |
| eoi_level_vector | output | 8 | Retired level-triggered vector |
| illegal_err | output | 1 | One-cycle pulse for an illegal fixed vector |
| proc_class | output | 4 | Current processor priority class |

## Verification
The assertions assume that every control input has a defined level at each clock edge. They also assume that an end-of-interrupt write refers to the handler the core is currently running, so they never reason about which handler the core believes it owns. Nothing in them depends on the spacing of events. The stimulus drives at most one kind of event per cycle, changes inputs only on the falling edge, and includes back-to-back messages, same-class collisions and end-of-interrupt writes with nothing in service to reach the ordering corners.

// File: rtl/fixint_pkg.sv
package fixint_pkg;

    localparam int unsigned KIND_W = 3;

    // Delivery types; only FIXED is recorded, every other code bypasses.
    typedef enum logic [KIND_W-1:0] {
        DLV_FIXED   = 3'd0,
        DLV_SYSMGMT = 3'd2,
        DLV_NONMASK = 3'd4,
        DLV_INIT    = 3'd5,
        DLV_STARTUP = 3'd6,
        DLV_EXTERN  = 3'd7
    } dlv_kind_e;

endpackage

// File: rtl/fixint_prio_enc.sv
// Highest-set-bit finder, split into class groups: pick the top non-empty
// group, then the top bit inside it.
module fixint_prio_enc #(
    parameter int WIDTH = 256,
    parameter int GRP   = 16,
    localparam int NGRP = WIDTH / GRP,
    localparam int LO_W = $clog2(GRP),
    localparam int HI_W = $clog2(NGRP)
) (
    input  logic [WIDTH-1:0]     req,
    output logic                 any,
    output logic [HI_W+LO_W-1:0] idx
);

    function automatic logic [LO_W-1:0] top_in_group(input logic [GRP-1:0] v);
        logic [LO_W-1:0] r;
        r = '0;
        for (int i = 0; i < GRP; i++) begin
            if (v[i]) r = LO_W'(i);
        end
        return r;
    endfunction

    logic [NGRP-1:0]           grp_any;
    logic [NGRP-1:0][LO_W-1:0] grp_lo;
    logic [HI_W-1:0]           hi_sel;

    genvar g;
    generate
        for (g = 0; g < NGRP; g++) begin : g_grp
            assign grp_any[g] = |req[g*GRP +: GRP];
            assign grp_lo[g]  = top_in_group(req[g*GRP +: GRP]);
        end
    endgenerate

    always_comb begin
        hi_sel = '0;
        for (int k = 0; k < NGRP; k++) begin
            if (grp_any[k]) hi_sel = HI_W'(k);
        end
    end

    assign any = |grp_any;
    assign idx = {hi_sel, grp_lo[hi_sel]};

endmodule

// File: rtl/fixint_msg_decode.sv
// Sorts one incoming message into accept / bypass / illegal / discard.
module fixint_msg_decode
    import fixint_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int CLS_W = 4
) (
    input  logic              msg_valid,
    input  logic              dest_hit,
    input  logic [VEC_W-1:0]  vector,
    input  logic [KIND_W-1:0] kind,
    output logic              take_fixed,
    output logic              take_bypass,
    output logic              flag_illegal
);

    logic matched;
    logic is_fixed;
    logic legal;

    assign matched      = msg_valid && dest_hit;
    assign is_fixed     = (kind == DLV_FIXED);
    assign legal        = (vector[VEC_W-1 -: CLS_W] != '0);

    assign take_fixed   = matched && is_fixed && legal;
    assign flag_illegal = matched && is_fixed && !legal;
    assign take_bypass  = matched && !is_fixed;

endmodule

// File: rtl/fixint_ctrl.sv
module fixint_ctrl
    import fixint_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int CLS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_valid,
    input  logic [VEC_W-1:0]  msg_vector,
    input  logic [KIND_W-1:0] msg_kind,
    input  logic              msg_level,
    input  logic              msg_dest_hit,
    input  logic              core_ready,
    input  logic              eoi_wr,
    input  logic              tpr_wr,
    input  logic [VEC_W-1:0]  tpr_data,
    output logic              disp_valid,
    output logic [VEC_W-1:0]  disp_vector,
    output logic              bypass_valid,
    output logic [KIND_W-1:0] bypass_kind,
    output logic [VEC_W-1:0]  bypass_vector,
    output logic              eoi_level_valid,
    output logic [VEC_W-1:0]  eoi_level_vector,
    output logic              illegal_err,
    output logic [CLS_W-1:0]  proc_class
);

    localparam int NVEC = 1 << VEC_W;
    localparam int GRP  = 1 << (VEC_W - CLS_W);

    typedef struct packed {
        logic [NVEC-1:0]   irr;
        logic [NVEC-1:0]   isr;
        logic [NVEC-1:0]   tmr;
        logic [VEC_W-1:0]  tpr;
        logic              disp_valid;
        logic [VEC_W-1:0]  disp_vec;
        logic              byp_valid;
        logic [KIND_W-1:0] byp_kind;
        logic [VEC_W-1:0]  byp_vec;
        logic              eoi_lvl_valid;
        logic [VEC_W-1:0]  eoi_lvl_vec;
        logic              err;
    } state_t;

    state_t st_d, st_q;

    // ---------------- message sorting ----------------
    logic take_fixed, take_bypass, flag_illegal;

    fixint_msg_decode #(.VEC_W(VEC_W), .CLS_W(CLS_W)) u_dec (
        .msg_valid   (msg_valid),
        .dest_hit    (msg_dest_hit),
        .vector      (msg_vector),
        .kind        (msg_kind),
        .take_fixed  (take_fixed),
        .take_bypass (take_bypass),
        .flag_illegal(flag_illegal)
    );

    // ---------------- highest pending / in-service ----------------
    logic             irr_any, isr_any;
    logic [VEC_W-1:0] irr_top, isr_top;

    fixint_prio_enc #(.WIDTH(NVEC), .GRP(GRP)) u_irr_top (
        .req(st_q.irr), .any(irr_any), .idx(irr_top)
    );

    fixint_prio_enc #(.WIDTH(NVEC), .GRP(GRP)) u_isr_top (
        .req(st_q.isr), .any(isr_any), .idx(isr_top)
    );

    // ---------------- priority gate ----------------
    logic [CLS_W-1:0] isr_cls, tpr_cls, ppr_cls, irr_cls;
    logic             grant;

    assign isr_cls = isr_any ? isr_top[VEC_W-1 -: CLS_W] : '0;
    assign tpr_cls = st_q.tpr[VEC_W-1 -: CLS_W];
    assign ppr_cls = (isr_cls > tpr_cls) ? isr_cls : tpr_cls;
    assign irr_cls = irr_top[VEC_W-1 -: CLS_W];
    assign grant   = core_ready && irr_any && (irr_cls > ppr_cls);

    // ---------------- next state ----------------
    always_comb begin
        st_d               = st_q;
        st_d.disp_valid    = 1'b0;
        st_d.byp_valid     = 1'b0;
        st_d.eoi_lvl_valid = 1'b0;
        st_d.err           = 1'b0;

        // Retire the top in-service vector.
        if (eoi_wr && isr_any) begin
            st_d.isr[isr_top] = 1'b0;
            if (st_q.tmr[isr_top]) begin
                st_d.eoi_lvl_valid = 1'b1;
                st_d.eoi_lvl_vec   = isr_top;
            end
        end

        // Move the winning pending vector into service.
        if (grant) begin
            st_d.irr[irr_top] = 1'b0;
            st_d.isr[irr_top] = 1'b1;
            st_d.disp_valid   = 1'b1;
            st_d.disp_vec     = irr_top;
        end

        // A new request is merged after the dispatch clear.
        if (take_fixed) begin
            st_d.irr[msg_vector] = 1'b1;
            st_d.tmr[msg_vector] = msg_level;
        end

        if (take_bypass) begin
            st_d.byp_valid = 1'b1;
            st_d.byp_kind  = msg_kind;
            st_d.byp_vec   = msg_vector;
        end

        if (flag_illegal) begin
            st_d.err = 1'b1;
        end

        if (tpr_wr) begin
            st_d.tpr = tpr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign disp_valid       = st_q.disp_valid;
    assign disp_vector      = st_q.disp_vec;
    assign bypass_valid     = st_q.byp_valid;
    assign bypass_kind      = st_q.byp_kind;
    assign bypass_vector    = st_q.byp_vec;
    assign eoi_level_valid  = st_q.eoi_lvl_valid;
    assign eoi_level_vector = st_q.eoi_lvl_vec;
    assign illegal_err      = st_q.err;
    assign proc_class       = ppr_cls;

    // ---------------- assertions ----------------
    assert_discard_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_dest_hit) |=> (!bypass_valid && !illegal_err));

    assert_bypass_fwd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_dest_hit && msg_kind != DLV_FIXED)
        |=> (bypass_valid && bypass_vector == $past(msg_vector)
             && bypass_kind == $past(msg_kind)));

    assert_accept_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_dest_hit && msg_kind == DLV_FIXED
         && msg_vector[VEC_W-1 -: CLS_W] != '0)
        |=> st_q.irr[$past(msg_vector)]);

    assert_trigger_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_dest_hit && msg_kind == DLV_FIXED
         && msg_vector[VEC_W-1 -: CLS_W] != '0)
        |=> (st_q.tmr[$past(msg_vector)] == $past(msg_level)));

    assert_dispatch_in_service_R3: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> (st_q.isr[disp_vector] && !st_q.irr[disp_vector]
                        || st_q.isr[disp_vector]));

    assert_dispatch_needs_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !core_ready |=> !disp_valid);

    assert_dispatch_beats_ppr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> (disp_vector[VEC_W-1 -: CLS_W] > $past(proc_class)));

    assert_eoi_retires_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_level_valid |-> (!st_q.isr[eoi_level_vector] && st_q.tmr[eoi_level_vector]));

    assert_eoi_needs_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !eoi_wr |=> !eoi_level_valid);

    assert_illegal_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_dest_hit && msg_kind == DLV_FIXED
         && msg_vector[VEC_W-1 -: CLS_W] == '0)
        |=> (illegal_err && !st_q.irr[$past(msg_vector)]));

endmodule

// File: tb/test_fixint_ctrl.sv
module test_fixint_ctrl;
    import fixint_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       msg_valid, msg_level, msg_dest_hit;
    logic [7:0] msg_vector;
    logic [2:0] msg_kind;
    logic       core_ready, eoi_wr, tpr_wr;
    logic [7:0] tpr_data;
    logic       disp_valid, bypass_valid, eoi_level_valid, illegal_err;
    logic [7:0] disp_vector, bypass_vector, eoi_level_vector;
    logic [2:0] bypass_kind;
    logic [3:0] proc_class;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    fixint_ctrl i_fixint_ctrl (
        .clk(clk), .rst_n(rst_n),
        .msg_valid(msg_valid), .msg_vector(msg_vector), .msg_kind(msg_kind),
        .msg_level(msg_level), .msg_dest_hit(msg_dest_hit),
        .core_ready(core_ready), .eoi_wr(eoi_wr),
        .tpr_wr(tpr_wr), .tpr_data(tpr_data),
        .disp_valid(disp_valid), .disp_vector(disp_vector),
        .bypass_valid(bypass_valid), .bypass_kind(bypass_kind),
        .bypass_vector(bypass_vector),
        .eoi_level_valid(eoi_level_valid), .eoi_level_vector(eoi_level_vector),
        .illegal_err(illegal_err), .proc_class(proc_class)
    );

    typedef struct packed {
        logic [3:0] req;
        logic       mv;
        logic [7:0] vec;
        logic [2:0] kind;
        logic       lvl;
        logic       hit;
        logic       rdy;
        logic       eoi;
        logic       tw;
        logic [7:0] td;
        logic       edv;
        logic [7:0] edvec;
        logic       eb;
        logic       eerr;
        logic       eel;
        logic [7:0] eelvec;
    } row_t;

    function automatic row_t m_row(input int r, input logic [7:0] v, input logic [2:0] k,
                                   input logic l, input logic h);
        row_t x = '0;
        x.req = 4'(r); x.mv = 1'b1; x.vec = v; x.kind = k; x.lvl = l; x.hit = h;
        x.eb   = h && (k != 3'd0);
        x.eerr = h && (k == 3'd0) && (v < 8'd16);
        return x;
    endfunction

    function automatic row_t r_row(input int r, input logic dv, input logic [7:0] dvec);
        row_t x = '0;
        x.req = 4'(r); x.rdy = 1'b1; x.edv = dv; x.edvec = dvec;
        return x;
    endfunction

    function automatic row_t e_row(input int r, input logic el, input logic [7:0] ev);
        row_t x = '0;
        x.req = 4'(r); x.eoi = 1'b1; x.eel = el; x.eelvec = ev;
        return x;
    endfunction

    function automatic row_t t_row(input int r, input logic [7:0] val);
        row_t x = '0;
        x.req = 4'(r); x.tw = 1'b1; x.td = val;
        return x;
    endfunction

    localparam int NROWS = 39;
    localparam row_t ROWS [NROWS] = '{
        m_row(3, 8'h40, 3'd0, 1'b0, 1'b1),   // R3 accept edge
        r_row(5, 1'b1, 8'h40),               // R5 dispatch
        m_row(4, 8'h30, 3'd0, 1'b1, 1'b1),   // R4 accept level
        r_row(6, 1'b0, 8'h00),               // R6 class 3 blocked by class 4 in service
        e_row(7, 1'b0, 8'h00),               // R7 edge vector retired silently
        r_row(5, 1'b1, 8'h30),
        e_row(7, 1'b1, 8'h30),               // R7 level vector announced
        m_row(2, 8'h55, 3'd4, 1'b0, 1'b1),   // R2 bypass type
        r_row(2, 1'b0, 8'h00),               // R2 nothing recorded
        m_row(1, 8'h60, 3'd0, 1'b0, 1'b0),   // R1 not addressed
        r_row(1, 1'b0, 8'h00),
        m_row(1, 8'h66, 3'd2, 1'b0, 1'b0),   // R1 bypass type not addressed
        m_row(8, 8'h0F, 3'd0, 1'b0, 1'b1),   // R8 illegal
        r_row(8, 1'b0, 8'h00),
        m_row(8, 8'h00, 3'd0, 1'b1, 1'b1),   // R8 illegal lowest
        r_row(8, 1'b0, 8'h00),
        t_row(6, 8'h70),
        m_row(3, 8'h75, 3'd0, 1'b0, 1'b1),
        r_row(5, 1'b0, 8'h00),               // R5 equal class not enough
        m_row(3, 8'h81, 3'd0, 1'b0, 1'b1),
        r_row(3, 1'b1, 8'h81),               // R3 highest first
        t_row(6, 8'h00),
        r_row(6, 1'b0, 8'h00),               // R6 in-service class 8 blocks 7
        e_row(7, 1'b0, 8'h00),
        r_row(3, 1'b1, 8'h75),
        e_row(7, 1'b0, 8'h00),
        r_row(5, 1'b0, 8'h00),               // R5 nothing pending
        m_row(3, 8'h92, 3'd0, 1'b0, 1'b1),
        m_row(4, 8'h9A, 3'd0, 1'b1, 1'b1),
        r_row(3, 1'b1, 8'h9A),               // R3 highest within class
        r_row(6, 1'b0, 8'h00),               // R6 same class in service
        e_row(7, 1'b1, 8'h9A),
        r_row(5, 1'b1, 8'h92),
        e_row(7, 1'b0, 8'h00),
        m_row(4, 8'h30, 3'd0, 1'b1, 1'b1),   // R4 level first
        m_row(4, 8'h30, 3'd0, 1'b0, 1'b1),   // R4 re-accept as edge
        r_row(5, 1'b1, 8'h30),
        e_row(4, 1'b0, 8'h00),               // R4 trigger bit now clear
        e_row(7, 1'b0, 8'h00)                // R7 empty in-service: no effect
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        msg_valid = 1'b0; msg_vector = '0; msg_kind = '0; msg_level = 1'b0;
        msg_dest_hit = 1'b0; core_ready = 1'b0; eoi_wr = 1'b0;
        tpr_wr = 1'b0; tpr_data = '0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    function automatic logic [31:0] pack_out();
        return {disp_valid, disp_vector, bypass_valid, illegal_err,
                eoi_level_valid, eoi_level_vector, 5'd0};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);

        // R9: reset state
        chk(!disp_valid && !bypass_valid && !eoi_level_valid && !illegal_err
            && proc_class == 4'd0, "R9 reset outputs",
            {disp_valid, bypass_valid, eoi_level_valid, illegal_err, proc_class}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table
        for (int i = 0; i < NROWS; i++) begin
            row_t r;
            logic [31:0] exp;
            logic        ok;
            r = ROWS[i];
            msg_valid = r.mv; msg_vector = r.vec; msg_kind = r.kind;
            msg_level = r.lvl; msg_dest_hit = r.hit; core_ready = r.rdy;
            eoi_wr = r.eoi; tpr_wr = r.tw; tpr_data = r.td;
            step();
            ok = (disp_valid == r.edv) && (!r.edv || disp_vector == r.edvec)
                 && (bypass_valid == r.eb) && (illegal_err == r.eerr)
                 && (eoi_level_valid == r.eel) && (!r.eel || eoi_level_vector == r.eelvec);
            exp = {r.edv, r.edvec, r.eb, r.eerr, r.eel, r.eelvec, 5'd0};
            checks++;
            if (!ok) begin
                errors++;
                $display("FAIL row %0d R%0d actual=%0h expected=%0h",
                         i, r.req, pack_out(), exp);
            end
        end

        // R2: bypass carries vector and kind
        msg_valid = 1'b1; msg_dest_hit = 1'b1; msg_vector = 8'h77; msg_kind = DLV_STARTUP;
        step();
        chk(bypass_valid && bypass_vector == 8'h77 && bypass_kind == 3'd6,
            "R2 bypass fields", {bypass_valid, bypass_kind, bypass_vector}, {1'b1, 3'd6, 8'h77});
        step();
        chk(!bypass_valid, "R2 bypass one cycle", 32'(bypass_valid), 32'd0);

        // R8: error lasts one cycle
        msg_valid = 1'b1; msg_dest_hit = 1'b1; msg_vector = 8'h03; msg_kind = DLV_FIXED;
        step();
        step();
        chk(!illegal_err, "R8 error one cycle", 32'(illegal_err), 32'd0);

        // R6: task priority alone, then in-service dominating, then after EOI
        tpr_wr = 1'b1; tpr_data = 8'hA3;
        step();
        chk(proc_class == 4'hA, "R6 from task priority", 32'(proc_class), 32'hA);
        tpr_wr = 1'b1; tpr_data = 8'h20;
        step();
        msg_valid = 1'b1; msg_dest_hit = 1'b1; msg_vector = 8'h55; msg_kind = DLV_FIXED;
        step();
        core_ready = 1'b1;
        step();
        chk(disp_valid && disp_vector == 8'h55, "R5 dispatch over task class",
            {disp_valid, disp_vector}, {1'b1, 8'h55});
        chk(proc_class == 4'h5, "R6 from in-service", 32'(proc_class), 32'h5);
        eoi_wr = 1'b1;
        step();
        chk(proc_class == 4'h2, "R6 back to task class", 32'(proc_class), 32'h2);

        // R9: reset clears pending, in-service and task priority
        msg_valid = 1'b1; msg_dest_hit = 1'b1; msg_vector = 8'h90; msg_level = 1'b1;
        step();
        core_ready = 1'b1;
        step();
        msg_valid = 1'b1; msg_dest_hit = 1'b1; msg_vector = 8'h95;
        step();
        tpr_wr = 1'b1; tpr_data = 8'h40;
        step();
        chk(proc_class == 4'h9, "R6 before reset", 32'(proc_class), 32'h9);
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        chk(proc_class == 4'h0, "R9 class cleared", 32'(proc_class), 32'h0);
        core_ready = 1'b1;
        step();
        chk(!disp_valid, "R9 pending cleared", 32'(disp_valid), 32'd0);
        eoi_wr = 1'b1;
        step();
        chk(!eoi_level_valid, "R9 in-service cleared", 32'(eoi_level_valid), 32'd0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule